// File: doc/BRIEF.md
# Pipeline Hazard Stall-and-Replay Controller

This block protects an in-order pipeline from read-after-write hazards without forwarding. Each cycle it takes the two source register indices of the instruction in the entry stage (s0) and compares each one with the destination index of each of the three younger-to-older stages s1, s2 and s3. A comparison counts only when that source's check enable is high and the stage's write enable is high. A destination of register 0 never counts, because register 0 reads as zero.

When a qualified match is found, the block raises a hazard flag. It then blocks the s0 instruction from advancing, for a fixed worst-case window of five cycles. The window is the detection cycle plus four cycles timed by a shift register. In the cycle after detection, the block issues a program-counter write carrying the address currently held in s1. The s1 program-counter register is never blocked, so s1 holds the address of the stalled instruction. That instruction is fetched again and follows the blocked bubbles, so it reads the updated register.

Control is a two-state machine. ST_IDLE waits for a hazard. ST_STALL walks a one-hot token through the shift register. Transition IDLE→STALL happens on an accepted detection and loads the token into stage 0. STALL→STALL shifts the token. STALL→IDLE happens when the token leaves the last stage. Detections seen in ST_STALL are ignored.

Top module: `hazard_replay_ctrl`

## Requirements
- R1: The hazard flag is high in a cycle, in ST_IDLE, exactly when rs1 or rs2 equals the destination index of s1, s2 or s3 under the qualifications of R2 to R4. This is a combinational result in the same cycle.
- R2: A source takes part in the comparison only while its own check enable (chk_rs1_i for rs1, chk_rs2_i for rs2) is 1.
- R3: A stage takes part in the comparison only while its write enable is 1.
- R4: A destination index of 0 never produces a match, even if the source index is also 0.
- R5: The block output is high in the detection cycle and in each of the four following cycles, five cycles in all, whatever stage held the conflicting writer. It is low otherwise.
- R6: pc_wr_o is high for exactly one cycle, the cycle after detection. In that cycle pc_val_o equals s1_pc_i. In every other cycle pc_val_o is 0.
- R7: While a stall window is running (the four cycles after detection), the hazard flag stays low. A match in those cycles neither restarts nor lengthens the window.
- R8: A synchronous active-high reset returns the block to ST_IDLE with the shift register cleared, so that with no match all outputs are 0.
- R9: In the first cycle after a window ends, a new match is accepted at once and starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rs1_i | input | IDX_W | First source index of the s0 instruction |
| rs2_i | input | IDX_W | Second source index of the s0 instruction |
| chk_rs1_i | input | 1 | rs1 is really read |
| chk_rs2_i | input | 1 | rs2 is really read |
| s1_rd_i | input | IDX_W | Destination index in s1 |
| s2_rd_i | input | IDX_W | Destination index in s2 |
| s3_rd_i | input | IDX_W | Destination index in s3 |
| s1_we_i | input | 1 | s1 writes its destination |
| s2_we_i | input | 1 | s2 writes its destination |
| s3_we_i | input | 1 | s3 writes its destination |
| s1_pc_i | input | PC_W | Program counter held in s1 |
| hazard_o | output | 1 | Accepted hazard detection |
| block_o | output | 1 | Keep s0 from entering s1 and later |
| pc_wr_o | output | 1 | Program-counter redirect strobe |
| pc_val_o | output | PC_W | Redirect address (0 when no strobe) |

## Verification
The hardest case to reach from the ports is a window that contains further matches. One kind arrives while the token is in the middle of the shift register and must be ignored. The other arrives in the first idle cycle after the token leaves and must be accepted. Purely random operands seldom line up that way. The stimulus therefore draws register indices from a small range and keeps write enables set most of the time, so matches are frequent. Directed sequences also hold a match steady through a whole window and into the cycle after it.

// File: rtl/hr_pkg.sv
package hr_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect #(
    parameter int IDX_W = 5,
    parameter int NST   = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [IDX_W-1:0]     src1_i,
    input  logic [IDX_W-1:0]     src2_i,
    input  logic                 use1_i,
    input  logic                 use2_i,
    input  logic [NST*IDX_W-1:0] dst_i,
    input  logic [NST-1:0]       wen_i,
    output logic                 match_o
);
    logic [NST-1:0] hit;

    // One comparator pair per younger stage
    for (genvar k = 0; k < NST; k++) begin : g_stage
        logic [IDX_W-1:0] dst;
        logic             live;
        assign dst  = dst_i[k*IDX_W +: IDX_W];
        assign live = wen_i[k] && (dst != '0);
        assign hit[k] = live && ((use1_i && (src1_i == dst)) ||
                                 (use2_i && (src2_i == dst)));
    end

    assign match_o = |hit;

    p_need_write_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |-> (|wen_i));
    p_need_check_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |-> (use1_i || use2_i));
    p_no_zero_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (dst_i == '0) |-> !match_o);
endmodule

// File: rtl/stall_timer.sv
module stall_timer
    import hr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic det_i,
    output logic hazard_o,
    output logic block_o,
    output logic pc_wr_o
);
    localparam logic [DEPTH-1:0] TOKEN = {{(DEPTH-1){1'b0}}, 1'b1};

    tmr_state_e       state, state_nx;
    logic [DEPTH-1:0] sr, sr_nx;
    logic             accept;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state <= ST_IDLE;
            sr    <= '0;
        end else begin
            state <= state_nx;
            sr    <= sr_nx;
        end
    end

    always_comb begin
        state_nx = state;
        sr_nx    = sr;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (det_i) begin
                    accept   = 1'b1;
                    sr_nx    = TOKEN;
                    state_nx = ST_STALL;
                end
            end
            ST_STALL: begin
                sr_nx = {sr[DEPTH-2:0], 1'b0};
                if (sr[DEPTH-1]) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        hazard_o = accept;
        block_o  = accept || (|sr);
        pc_wr_o  = sr[0];
    end

    p_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        hazard_o |=> (sr == TOKEN));
    p_onehot_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(sr));
    p_end_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        sr[DEPTH-1] |=> (state == ST_IDLE && sr == '0));
    p_pc_after_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_wr_o |-> $past(hazard_o));
    p_ignore_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|sr) && !sr[DEPTH-1]) |=> (sr == {$past(sr[DEPTH-2:0]), 1'b0}));
    p_reset_r8: assert property (@(posedge clk_i)
        rst_i |=> (state == ST_IDLE && sr == '0));
endmodule

// File: rtl/hazard_replay_ctrl.sv
module hazard_replay_ctrl #(
    parameter int IDX_W = 5,
    parameter int PC_W  = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [IDX_W-1:0] rs1_i,
    input  logic [IDX_W-1:0] rs2_i,
    input  logic             chk_rs1_i,
    input  logic             chk_rs2_i,
    input  logic [IDX_W-1:0] s1_rd_i,
    input  logic [IDX_W-1:0] s2_rd_i,
    input  logic [IDX_W-1:0] s3_rd_i,
    input  logic             s1_we_i,
    input  logic             s2_we_i,
    input  logic             s3_we_i,
    input  logic [PC_W-1:0]  s1_pc_i,
    output logic             hazard_o,
    output logic             block_o,
    output logic             pc_wr_o,
    output logic [PC_W-1:0]  pc_val_o
);
    localparam int NST = 3;

    logic [NST*IDX_W-1:0] dst_all;
    logic [NST-1:0]       wen_all;
    logic                 det;

    assign dst_all = {s3_rd_i, s2_rd_i, s1_rd_i};
    assign wen_all = {s3_we_i, s2_we_i, s1_we_i};

    hazard_detect #(.IDX_W(IDX_W), .NST(NST)) u_detect (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .src1_i  (rs1_i),
        .src2_i  (rs2_i),
        .use1_i  (chk_rs1_i),
        .use2_i  (chk_rs2_i),
        .dst_i   (dst_all),
        .wen_i   (wen_all),
        .match_o (det)
    );

    stall_timer #(.DEPTH(DEPTH)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .det_i    (det),
        .hazard_o (hazard_o),
        .block_o  (block_o),
        .pc_wr_o  (pc_wr_o)
    );

    assign pc_val_o = pc_wr_o ? s1_pc_i : '0;

    p_pc_quiet_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !pc_wr_o |-> (pc_val_o == '0));
    p_block_cover_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hazard_o || pc_wr_o) |-> block_o);
endmodule

// File: tb/test_hazard_replay_ctrl.sv
module test_hazard_replay_ctrl;
    localparam int IDX_W = 5;
    localparam int PC_W  = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDX_W-1:0] rs1 = '0, rs2 = '0, d1 = '0, d2 = '0, d3 = '0;
    logic             c1 = 1'b0, c2 = 1'b0, w1 = 1'b0, w2 = 1'b0, w3 = 1'b0;
    logic [PC_W-1:0]  pc = '0;
    logic             hz, blk, pcw;
    logic [PC_W-1:0]  pcv;

    int total = 0;
    int bad   = 0;
    int cnt   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hazard_replay_ctrl i_hazard_replay_ctrl (
        .clk_i(clk), .rst_i(rst), .rs1_i(rs1), .rs2_i(rs2),
        .chk_rs1_i(c1), .chk_rs2_i(c2),
        .s1_rd_i(d1), .s2_rd_i(d2), .s3_rd_i(d3),
        .s1_we_i(w1), .s2_we_i(w2), .s3_we_i(w3),
        .s1_pc_i(pc), .hazard_o(hz), .block_o(blk),
        .pc_wr_o(pcw), .pc_val_o(pcv)
    );

    function automatic bit one_hit(logic [IDX_W-1:0] d, logic w);
        if (!w || d == 0) return 1'b0;
        return (c1 && rs1 == d) || (c2 && rs2 == d);
    endfunction

    function automatic bit exp_raw();
        return one_hit(d1, w1) || one_hit(d2, w2) || one_hit(d3, w3);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive already done; check outputs mid-cycle, then advance the model at the edge
    task automatic step(string hz_tag);
        bit e_hz, e_pw;
        #5;
        e_hz = (cnt == 0) && exp_raw();
        e_pw = (cnt == 1);
        check((cnt != 0) ? "R7" : hz_tag, "hazard", hz, e_hz);
        check("R5", "block", blk, e_hz || cnt != 0);
        check("R6", "pc_wr", pcw, e_pw);
        check("R6", "pc_val", pcv, e_pw ? pc : 0);
        @(posedge clk);
        if (cnt == 0 && e_hz) cnt = 1;
        else if (cnt == 4)    cnt = 0;
        else if (cnt != 0)    cnt++;
        @(negedge clk);
    endtask

    task automatic set_ops(logic [IDX_W-1:0] a, logic [IDX_W-1:0] b, logic ca, logic cb,
                           logic [IDX_W-1:0] x, logic [IDX_W-1:0] y, logic [IDX_W-1:0] z,
                           logic wx, logic wy, logic wz);
        rs1 = a; rs2 = b; c1 = ca; c2 = cb;
        d1 = x; d2 = y; d3 = z; w1 = wx; w2 = wy; w3 = wz;
        pc = $urandom;
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state, no match
        check("R8", "hazard", hz, 0);
        check("R8", "block", blk, 0);
        check("R8", "pc_wr", pcw, 0);
        rst = 1'b0;

        // R2: match present but check enables off
        set_ops(5, 6, 0, 0, 5, 6, 5, 1, 1, 1); step("R2");
        // R3: match present but write enables off
        set_ops(5, 6, 1, 1, 5, 6, 5, 0, 0, 0); step("R3");
        // R4: destination 0 never matches
        set_ops(0, 0, 1, 1, 0, 0, 0, 1, 1, 1); step("R4");
        // R1: rs2 against s3; then hold a match through the window (R7) and beyond (R9)
        set_ops(1, 9, 0, 1, 2, 3, 9, 1, 1, 1); step("R1");
        for (int i = 0; i < 4; i++) begin
            set_ops(2, 2, 1, 1, 2, 2, 2, 1, 1, 1); step("R7");
        end
        set_ops(7, 4, 1, 0, 7, 0, 0, 1, 0, 0); step("R9");
        repeat (5) begin
            set_ops(3, 3, 0, 0, 3, 3, 3, 1, 1, 1); step("R1");
        end

        // Constrained random: small index range and frequent write enables
        for (int n = 0; n < 3000; n++) begin
            set_ops($urandom_range(0, 3), $urandom_range(0, 3),
                    ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
                    $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                    $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0,
                    $urandom_range(0, 2) != 0);
            step("R1");
            if (n == 1500) begin
                // R8: reset in mid-stream clears any window
                rst = 1'b1;
                set_ops(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
                @(posedge clk); @(negedge clk);
                rst = 1'b0;
                cnt = 0;
                #5;
                check("R8", "block", blk, 0);
                check("R8", "pc_wr", pcw, 0);
                @(negedge clk);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule